// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Unit

This unit sits between a processor's memory stage and a 32-bit word-wide data memory that has one write enable per byte. The core hands it one access per cycle: a byte address, a size (byte, halfword or word), a direction, a zero-extend flag and, for stores, the source register value. The unit registers a memory request that carries the word address, the byte enables and the store data already moved onto the right byte lanes. For loads, it takes the word the memory returns one cycle later, picks out the addressed byte or halfword and widens it to 32 bits.

Lanes are numbered big-endian. The byte at address offset 0 inside a word travels on bits 31:24, and the byte at offset 3 travels on bits 7:0. A halfword at offset 0 uses bits 31:16 and one at offset 2 uses bits 15:0. An access that breaks its alignment rule, or that uses the reserved size code, raises an error pulse and never reaches the memory. Handling that error belongs to the core.

Top module: `be_lane_unit`

## Requirements
- R1: While reset is asserted, and directly after reset is asserted in the middle of an access, mem_req, acc_err and ld_valid are low and mem_be is zero.
- R2: A request accepted with req_valid at a clock edge appears on mem_req, mem_we and mem_addr (req_addr bits 31:2) from that edge until the next one. req_write=1 means store.
- R3: A word store (req_size=2'b10) at offset 0 drives mem_be=4'b1111 and passes req_wdata unchanged to mem_wdata.
- R4: A halfword store (req_size=2'b01) drives mem_be=4'b1100 at offset 0 and 4'b0011 at offset 2. mem_wdata carries req_wdata[15:0] in both halves.
- R5: A byte store (req_size=2'b00) drives mem_be=4'b1000 shifted right by the offset, so mem_be bit 3 stands for bits 31:24. mem_wdata carries req_wdata[7:0] in all four lanes.
- R6: A halfword at an odd offset, a word at a nonzero offset, or req_size=2'b11 raises acc_err for one cycle with mem_req low and mem_be zero. A misaligned load produces no ld_valid.
- R7: One cycle after an aligned load request, ld_valid is high and ld_data is formed from mem_rdata in that cycle. A word load returns mem_rdata unchanged.
- R8: A byte load at offset k returns the byte on mem_rdata bits 31-8k down to 24-8k.
- R9: A halfword load returns mem_rdata[31:16] at offset 0 and mem_rdata[15:0] at offset 2.
- R10: With req_unsigned=0, byte and halfword loads copy the loaded value's top bit into all upper bits of ld_data.
- R11: With req_unsigned=1, byte and halfword loads fill the upper bits of ld_data with zeros.
- R12: In a cycle with no memory request, mem_be is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | An access is presented this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_unsigned | input | 1 | Load widening: 1 = zero-fill, 0 = sign-fill |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_addr | input | 32 | Byte address of the access |
| req_wdata | input | 32 | Store source value (low bits used for byte/halfword) |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 30 | Word address |
| mem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Store data on its lanes |
| mem_rdata | input | 32 | Word returned by memory one cycle after a read |
| acc_err | output | 1 | Misaligned or reserved-size access |
| ld_valid | output | 1 | ld_data holds a load result |
| ld_data | output | 32 | Widened load result |

## Verification
On every cycle, assertions check the following. An idle cycle carries no byte enables. An error never comes with a memory strobe. The number of enables matches the registered size. A load result only follows a read strobe. Sign-filled and zero-filled results have the right upper bits. The exact lane chosen for each offset, the replication pattern of store data and the mapping of addresses to word addresses are shown only by the bench's table of stores and loads, together with its directed reset and idle scenarios.

// File: rtl/be_lane_pkg.sv
package be_lane_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/be_lane_store.sv
// Store-side lane steering and alignment check (combinational).
module be_lane_store
  import be_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [OFF_W-1:0]  off,
  input  acc_size_e         size,
  input  logic [DATA_W-1:0] src,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] lane_data,
  output logic              misalign
);

  always_comb begin
    unique case (size)
      SZ_BYTE: misalign = 1'b0;
      SZ_HALF: misalign = off[0];
      SZ_WORD: misalign = |off;
      default: misalign = 1'b1;
    endcase
  end

  // Lane i holds the byte at offset i; big-endian puts offset 0 on the top byte.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [OFF_W-1:0] LOFF = OFF_W'(i);
    localparam int HSEL = (i % 2 == 0) ? 15 : 7;
    logic       hit;
    logic [7:0] byte_v;

    always_comb begin
      unique case (size)
        SZ_BYTE: hit = (off == LOFF);
        SZ_HALF: hit = (off[OFF_W-1:1] == LOFF[OFF_W-1:1]);
        SZ_WORD: hit = 1'b1;
        default: hit = 1'b0;
      endcase
    end

    always_comb begin
      unique case (size)
        SZ_BYTE: byte_v = src[7:0];
        SZ_HALF: byte_v = src[HSEL -: 8];
        SZ_WORD: byte_v = src[DATA_W-1-8*i -: 8];
        default: byte_v = '0;
      endcase
    end

    assign be[LANES-1-i]                = hit & ~misalign;
    assign lane_data[DATA_W-1-8*i -: 8] = byte_v;
  end

endmodule

// File: rtl/be_lane_extract.sv
// Load-side lane selection and widening (combinational).
module be_lane_extract
  import be_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [OFF_W-1:0]  off,
  input  acc_size_e         size,
  input  logic              zext,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] result
);

  logic [7:0]  lane [LANES];
  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  for (genvar i = 0; i < LANES; i++) begin : g_split
    assign lane[i] = rdata[DATA_W-1-8*i -: 8];
  end

  always_comb begin
    sel_b = lane[off];
    sel_h = {lane[{off[OFF_W-1:1], 1'b0}], lane[{off[OFF_W-1:1], 1'b1}]};
    unique case (size)
      SZ_BYTE: result = zext ? {{(DATA_W-8){1'b0}}, sel_b}
                             : {{(DATA_W-8){sel_b[7]}}, sel_b};
      SZ_HALF: result = zext ? {{(DATA_W-16){1'b0}}, sel_h}
                             : {{(DATA_W-16){sel_h[15]}}, sel_h};
      default: result = rdata;
    endcase
  end

endmodule

// File: rtl/be_lane_unit.sv
// Big-endian load/store lane unit: registered memory request, load widening
// on the word returned one cycle after the read strobe.
module be_lane_unit
  import be_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int WA_W  = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_unsigned,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WA_W-1:0]   mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              acc_err,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);

  // ---------------- reset: async assert, sync release ----------------
  logic rs_meta, rs_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_q_n  <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_q_n  <= rs_meta;
    end
  end

  // ---------------- request decode ----------------
  acc_size_e             sz_in;
  logic [OFF_W-1:0]      off_in;
  logic [LANES-1:0]      be_c;
  logic [DATA_W-1:0]     wdata_c;
  logic                  mis_c;

  assign sz_in  = acc_size_e'(req_size);
  assign off_in = req_addr[OFF_W-1:0];

  be_lane_store #(.DATA_W(DATA_W)) u_store (
    .off       (off_in),
    .size      (sz_in),
    .src       (req_wdata),
    .be        (be_c),
    .lane_data (wdata_c),
    .misalign  (mis_c)
  );

  // ---------------- stage A: memory request ----------------
  logic              req_q, we_q, err_q, ald_q, a_uns_q;
  logic [WA_W-1:0]   addr_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] wd_q;
  logic [OFF_W-1:0]  a_off_q;
  acc_size_e         a_size_q;

  logic              req_d, err_d, ald_d, a_en;
  logic [LANES-1:0]  be_d;

  always_comb begin
    a_en  = req_valid;
    req_d = req_valid & ~mis_c;
    err_d = req_valid & mis_c;
    ald_d = req_valid & ~mis_c & ~req_write;
    be_d  = req_valid ? be_c : '0;
  end

  always_ff @(posedge clk or negedge rs_q_n) begin
    if (!rs_q_n) begin
      req_q <= 1'b0;
      err_q <= 1'b0;
      ald_q <= 1'b0;
      be_q  <= '0;
    end else begin
      req_q <= req_d;
      err_q <= err_d;
      ald_q <= ald_d;
      be_q  <= be_d;
    end
  end

  always_ff @(posedge clk or negedge rs_q_n) begin
    if (!rs_q_n) begin
      we_q     <= 1'b0;
      addr_q   <= '0;
      wd_q     <= '0;
      a_off_q  <= '0;
      a_size_q <= SZ_BYTE;
      a_uns_q  <= 1'b0;
    end else if (a_en) begin
      we_q     <= req_write;
      addr_q   <= req_addr[ADDR_W-1:OFF_W];
      wd_q     <= wdata_c;
      a_off_q  <= off_in;
      a_size_q <= sz_in;
      a_uns_q  <= req_unsigned;
    end
  end

  assign mem_req   = req_q;
  assign mem_we    = req_q & we_q;
  assign mem_addr  = addr_q;
  assign mem_be    = be_q;
  assign mem_wdata = wd_q;
  assign acc_err   = err_q;

  // ---------------- stage B: load return ----------------
  logic             b_vld_q, b_uns_q, b_en;
  logic [OFF_W-1:0] b_off_q;
  acc_size_e        b_size_q;

  assign b_en = ald_q;

  always_ff @(posedge clk or negedge rs_q_n) begin
    if (!rs_q_n) b_vld_q <= 1'b0;
    else         b_vld_q <= ald_q;
  end

  always_ff @(posedge clk or negedge rs_q_n) begin
    if (!rs_q_n) begin
      b_off_q  <= '0;
      b_size_q <= SZ_BYTE;
      b_uns_q  <= 1'b0;
    end else if (b_en) begin
      b_off_q  <= a_off_q;
      b_size_q <= a_size_q;
      b_uns_q  <= a_uns_q;
    end
  end

  be_lane_extract #(.DATA_W(DATA_W)) u_extract (
    .off    (b_off_q),
    .size   (b_size_q),
    .zext   (b_uns_q),
    .rdata  (mem_rdata),
    .result (ld_data)
  );

  assign ld_valid = b_vld_q;

  // ---------------- assertions ----------------
  AST_IDLE_NO_ENABLES: assert property (@(posedge clk) disable iff (!rs_q_n)
    !mem_req |-> (mem_be == '0));                                        // R12
  AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rs_q_n)
    acc_err |-> !mem_req);                                               // R6
  AST_REQ_FROM_VALID: assert property (@(posedge clk) disable iff (!rs_q_n)
    mem_req |-> $past(req_valid));                                       // R2
  AST_ENABLE_COUNT: assert property (@(posedge clk) disable iff (!rs_q_n)
    mem_req |-> ($countones(mem_be) ==
                 ((a_size_q == SZ_BYTE) ? 1 : (a_size_q == SZ_HALF) ? 2 : LANES))); // R3
  AST_LOAD_AFTER_READ: assert property (@(posedge clk) disable iff (!rs_q_n)
    ld_valid |-> $past(mem_req && !mem_we));                             // R7
  AST_SIGN_FILL: assert property (@(posedge clk) disable iff (!rs_q_n)
    (ld_valid && !b_uns_q && b_size_q == SZ_BYTE) |->
      (ld_data[DATA_W-1:8] == {(DATA_W-8){ld_data[7]}}));                // R10
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rs_q_n)
    (ld_valid && b_uns_q && b_size_q != SZ_WORD) |->
      (ld_data[DATA_W-1:16] == '0));                                     // R11

endmodule

// File: tb/tb_be_lane_unit.sv
module tb_be_lane_unit;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_unsigned;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata;
  logic        mem_req, mem_we;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata;
  logic        acc_err, ld_valid;
  logic [31:0] ld_data;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  be_lane_unit dut (
    .clk, .rst_n, .req_valid, .req_write, .req_unsigned, .req_size,
    .req_addr, .req_wdata, .mem_req, .mem_we, .mem_addr, .mem_be,
    .mem_wdata, .mem_rdata, .acc_err, .ld_valid, .ld_data
  );

  typedef struct packed {
    logic        wr;
    logic        uns;
    logic [1:0]  sz;
    logic [1:0]  off;
    logic [31:0] wd;
    logic [31:0] rd;
    logic        err;
    logic [3:0]  be;
    logic [31:0] ex;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,2'b10,2'd0,32'h11223344,32'h0,       1'b0,4'hF,32'h11223344},
    '{1'b1,1'b0,2'b01,2'd0,32'hAABBCCDD,32'h0,       1'b0,4'hC,32'hCCDDCCDD},
    '{1'b1,1'b0,2'b01,2'd2,32'hAABBCCDD,32'h0,       1'b0,4'h3,32'hCCDDCCDD},
    '{1'b1,1'b0,2'b00,2'd0,32'h12345678,32'h0,       1'b0,4'h8,32'h78787878},
    '{1'b1,1'b0,2'b00,2'd1,32'h12345678,32'h0,       1'b0,4'h4,32'h78787878},
    '{1'b1,1'b0,2'b00,2'd2,32'h9ABCDEF0,32'h0,       1'b0,4'h2,32'hF0F0F0F0},
    '{1'b1,1'b0,2'b00,2'd3,32'h9ABCDEF0,32'h0,       1'b0,4'h1,32'hF0F0F0F0},
    '{1'b1,1'b0,2'b10,2'd2,32'h11223344,32'h0,       1'b1,4'h0,32'h0},
    '{1'b1,1'b0,2'b01,2'd1,32'h11223344,32'h0,       1'b1,4'h0,32'h0},
    '{1'b1,1'b0,2'b11,2'd0,32'h11223344,32'h0,       1'b1,4'h0,32'h0},
    '{1'b0,1'b0,2'b10,2'd1,32'h0,       32'h80FF7F01,1'b1,4'h0,32'h0},
    '{1'b0,1'b0,2'b00,2'd0,32'h0,       32'h80FF7F01,1'b0,4'h8,32'hFFFFFF80},
    '{1'b0,1'b1,2'b00,2'd0,32'h0,       32'h80FF7F01,1'b0,4'h8,32'h00000080},
    '{1'b0,1'b0,2'b00,2'd1,32'h0,       32'h80FF7F01,1'b0,4'h4,32'hFFFFFFFF},
    '{1'b0,1'b1,2'b00,2'd1,32'h0,       32'h80FF7F01,1'b0,4'h4,32'h000000FF},
    '{1'b0,1'b0,2'b00,2'd2,32'h0,       32'h80FF7F01,1'b0,4'h2,32'h0000007F},
    '{1'b0,1'b1,2'b00,2'd3,32'h0,       32'h80FF7F01,1'b0,4'h1,32'h00000001},
    '{1'b0,1'b0,2'b01,2'd0,32'h0,       32'h80FF7F01,1'b0,4'hC,32'hFFFF80FF},
    '{1'b0,1'b1,2'b01,2'd0,32'h0,       32'h80FF7F01,1'b0,4'hC,32'h000080FF},
    '{1'b0,1'b0,2'b01,2'd2,32'h0,       32'h80FF7F01,1'b0,4'h3,32'h00007F01},
    '{1'b0,1'b0,2'b01,2'd2,32'h0,       32'h1234F00D,1'b0,4'h3,32'hFFFFF00D},
    '{1'b0,1'b1,2'b01,2'd2,32'h0,       32'h1234F00D,1'b0,4'h3,32'h0000F00D},
    '{1'b0,1'b0,2'b10,2'd0,32'h0,       32'h80FF7F01,1'b0,4'hF,32'h80FF7F01},
    '{1'b0,1'b1,2'b10,2'd0,32'h0,       32'h80000001,1'b0,4'hF,32'h80000001}
  };

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.err) return "R6";
    if (v.wr) begin
      if (v.sz == 2'b10) return "R3";
      if (v.sz == 2'b01) return "R4";
      return "R5";
    end
    if (v.sz == 2'b10) return "R7";
    if (v.sz == 2'b00) return v.uns ? "R8/R11" : "R8/R10";
    return v.uns ? "R9/R11" : "R9/R10";
  endfunction

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_unsigned = 1'b0;
    req_size = 2'b00; req_addr = '0; req_wdata = '0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "mem_req", 32'(mem_req), 32'd0);
    check("R1", "acc_err", 32'(acc_err), 32'd0);
    check("R1", "ld_valid", 32'(ld_valid), 32'd0);
    check("R1", "mem_be", 32'(mem_be), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [31:0] a;
      string t;
      v = VECS[i];
      t = tag_of(v);
      a = 32'h0000_4000 + 32'(i * 16) + 32'(v.off);
      req_valid = 1'b1; req_write = v.wr; req_unsigned = v.uns;
      req_size = v.sz; req_addr = a; req_wdata = v.wd;
      @(negedge clk);
      req_valid = 1'b0;
      check(v.err ? "R6" : "R2", "mem_req", 32'(mem_req), 32'(!v.err));
      check(t, "acc_err", 32'(acc_err), 32'(v.err));
      check(t, "mem_be", 32'(mem_be), 32'(v.be));
      if (!v.err) begin
        check("R2", "mem_addr", 32'(mem_addr), 32'(a[31:2]));
        check("R2", "mem_we", 32'(mem_we), 32'(v.wr));
      end
      if (v.wr && !v.err) check(t, "mem_wdata", mem_wdata, v.ex);
      mem_rdata = v.rd;
      @(negedge clk);
      check(v.err ? "R6" : "R7", "ld_valid", 32'(ld_valid), 32'(!v.wr && !v.err));
      if (!v.wr && !v.err) check(t, "ld_data", ld_data, v.ex);
    end

    // R12: idle cycle carries no enables
    @(negedge clk);
    check("R12", "mem_be", 32'(mem_be), 32'd0);
    check("R12", "mem_req", 32'(mem_req), 32'd0);

    // R1: reset asserted while a load is in flight
    req_valid = 1'b1; req_write = 1'b0; req_unsigned = 1'b0;
    req_size = 2'b10; req_addr = 32'h0000_8000; req_wdata = '0;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2", "mem_req before reset", 32'(mem_req), 32'd1);
    rst_n = 1'b0;
    #1;
    check("R1", "mem_req after reset", 32'(mem_req), 32'd0);
    check("R1", "mem_be after reset", 32'(mem_be), 32'd0);
    @(negedge clk);
    check("R1", "ld_valid after reset", 32'(ld_valid), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "acc_err after release", 32'(acc_err), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule